// File: doc/BRIEF.md
# Multiplexed LCD Drive Waveform Sequencer

This block produces, slot by slot, the drive level codes for the backplane and segment outputs of a passive LCD panel. An external analog selector turns each 3-bit code into one of the panel voltages. The block supports a static mode with one backplane and multiplexed modes with two, three or four backplanes. The multiplexed modes run at either one-third or one-half bias. An external clock divider supplies a slot tick. At every tick the sequencer moves on to the next time slot and presents the index of the backplane row now being scanned. Display RAM returns the on/off bits for that row on `seg_bits`.

A frame has two halves, and each half scans every active row once. In the second half every level is mirrored about mid-supply, so each cell sees zero average voltage over a frame. The mode and bias inputs are taken in only when a frame ends, so a frame is never driven partly in one mode and partly in another. When the display is disabled, every output sits at the lowest level, so no segment sees any voltage. Backplanes that the current mode does not use stay at the lowest level at all times.

Top module: `lcd_wave_seq`

## Requirements
- R1: A mode value m (0 static, 1 two rows, 2 three rows, 3 four rows) gives N = m+1 active rows. `row_sel` steps 0,1,..,N-1 on each tick and then starts again at 0, and it never exceeds N-1. A frame has 2N slots: rows 0..N-1 in the first half, then rows 0..N-1 again in the second half.
- R2: The level codes are 0 = VSS, 1 = one third of VLCD, 2 = half of VLCD, 3 = two thirds of VLCD and 4 = VLCD. No output field ever holds a value above 4.
- R3: In static mode (m=0) the backplane is 4 in the first half and 0 in the second half. A segment whose bit is 1 takes the opposite level (0 in the first half, 4 in the second), and a segment whose bit is 0 takes the same level as the backplane.
- R4: In a multiplexed mode with `bias_half`=0 (one-third bias), in the first half the scanned backplane is 4 and the other active backplanes are 1. A segment with bit 1 is 0 and a segment with bit 0 is 3. In the second half every code c becomes 4-c.
- R5: In a multiplexed mode with `bias_half`=1 (one-half bias), in the first half the scanned backplane is 4, the other active backplanes are 2, a segment with bit 1 is 0 and a segment with bit 0 is 2. In the second half every code c becomes 4-c. In static mode `bias_half` has no effect.
- R6: A backplane whose index is above m outputs 0 at all times.
- R7: When `disp_en` is 0, every backplane and segment field is 0 from the next clock edge on.
- R8: `mode_sel` and `bias_half` take effect only at the tick that ends the last slot of a frame. After reset the block runs four rows at one-third bias.
- R9: `row_sel` changes on the clock edge that samples a tick. The level outputs are registered and follow the new slot one clock edge later.
- R10: A synchronous active-high reset sets `row_sel`, the slot phase and every output field to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous reset, active high |
| tick | input | 1 | one-cycle pulse that advances one slot |
| mode_sel | input | 2 | requested mode (0 static, 1..3 two to four rows) |
| bias_half | input | 1 | 1 = one-half bias, 0 = one-third bias |
| disp_en | input | 1 | 0 blanks every output |
| seg_bits | input | 60 | on/off bits of the row given by `row_sel` |
| row_sel | output | 2 | row now being scanned |
| bp_lvl | output | 12 | backplane level codes, 3 bits each, backplane k at [3k+2:3k] |
| seg_lvl | output | 180 | segment level codes, 3 bits each, segment j at [3j+2:3j] |

## Verification
A tick is sampled at one clock edge, and that edge moves `row_sel` and, at the end of a frame, the active configuration. The level codes for the new slot appear one edge later. `disp_en` acts on the levels at the first edge after it changes. The bench raises each tick for one cycle and then waits two edges before it compares the row and every level field against its own slot model. One directed check samples after only the first edge, to confirm that the row has already moved while the levels still show the previous slot. Blanking is checked after a single edge with no tick.

// File: rtl/lcd_wave_pkg.sv
package lcd_wave_pkg;
  localparam int LVL_W = 3;
  typedef logic [LVL_W-1:0] lvl_t;

  localparam lvl_t LV_VSS  = 3'd0;
  localparam lvl_t LV_THRD = 3'd1;
  localparam lvl_t LV_HALF = 3'd2;
  localparam lvl_t LV_TWO3 = 3'd3;
  localparam lvl_t LV_FULL = 3'd4;

  // second half of a frame: reflect about mid-supply
  function automatic lvl_t lvl_mirror(lvl_t c, logic neg);
    return neg ? lvl_t'(LV_FULL - c) : c;
  endfunction

  function automatic lvl_t bp_base(logic sel, logic stat, logic half);
    if (sel || stat) return LV_FULL;
    return half ? LV_HALF : LV_THRD;
  endfunction

  function automatic lvl_t seg_base(logic on, logic stat, logic half);
    if (on) return LV_VSS;
    if (stat) return LV_FULL;
    return half ? LV_HALF : LV_TWO3;
  endfunction
endpackage

// File: rtl/lcd_slot_ctrl.sv
module lcd_slot_ctrl #(
  parameter int NBP = 4,
  localparam int RW = $clog2(NBP)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic [RW-1:0] mode_in,
  input  logic          bias_in,
  output logic [RW-1:0] row,
  output logic          neg,
  output logic [RW-1:0] act_mode,
  output logic          act_half
);
  logic row_last;
  assign row_last = (row == act_mode);

  always_ff @(posedge clk) begin
    if (rst) begin
      row      <= '0;
      neg      <= 1'b0;
      act_mode <= RW'(NBP-1);
      act_half <= 1'b0;
    end else if (tick) begin
      if (row_last) begin
        row <= '0;
        neg <= ~neg;
        if (neg) begin
          act_mode <= mode_in;
          act_half <= bias_in;
        end
      end else begin
        row <= row + 1'b1;
      end
    end
  end
endmodule

// File: rtl/lcd_bp_drive.sv
module lcd_bp_drive
  import lcd_wave_pkg::*;
#(
  parameter int NBP = 4,
  localparam int RW = $clog2(NBP)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  input  logic [RW-1:0]      row,
  input  logic               neg,
  input  logic [RW-1:0]      act_mode,
  input  logic               act_half,
  output logic [NBP*LVL_W-1:0] bp_lvl
);
  logic stat;
  assign stat = (act_mode == '0);

  for (genvar k = 0; k < NBP; k++) begin : g_bp
    logic used, sel;
    lvl_t nxt;
    assign used = (k <= int'(act_mode));
    assign sel  = (row == RW'(k));
    always_comb begin
      if (!en || !used) nxt = LV_VSS;
      else nxt = lvl_mirror(bp_base(sel, stat, act_half), neg);
    end
    always_ff @(posedge clk) begin
      if (rst) bp_lvl[k*LVL_W +: LVL_W] <= LV_VSS;
      else     bp_lvl[k*LVL_W +: LVL_W] <= nxt;
    end
  end
endmodule

// File: rtl/lcd_seg_drive.sv
module lcd_seg_drive
  import lcd_wave_pkg::*;
#(
  parameter int NSEG = 60
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  en,
  input  logic                  neg,
  input  logic                  stat,
  input  logic                  act_half,
  input  logic [NSEG-1:0]       seg_on,
  output logic [NSEG*LVL_W-1:0] seg_lvl
);
  for (genvar j = 0; j < NSEG; j++) begin : g_seg
    lvl_t nxt;
    always_comb begin
      if (!en) nxt = LV_VSS;
      else nxt = lvl_mirror(seg_base(seg_on[j], stat, act_half), neg);
    end
    always_ff @(posedge clk) begin
      if (rst) seg_lvl[j*LVL_W +: LVL_W] <= LV_VSS;
      else     seg_lvl[j*LVL_W +: LVL_W] <= nxt;
    end
  end
endmodule

// File: rtl/lcd_wave_seq.sv
module lcd_wave_seq #(
  parameter int NBP  = 4,
  parameter int NSEG = 60,
  localparam int RW = $clog2(NBP),
  localparam int LW = lcd_wave_pkg::LVL_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick,
  input  logic [RW-1:0]      mode_sel,
  input  logic               bias_half,
  input  logic               disp_en,
  input  logic [NSEG-1:0]    seg_bits,
  output logic [RW-1:0]      row_sel,
  output logic [NBP*LW-1:0]  bp_lvl,
  output logic [NSEG*LW-1:0] seg_lvl
);
  logic          neg, act_half;
  logic [RW-1:0] act_mode;

  lcd_slot_ctrl #(.NBP(NBP)) u_ctrl (
    .clk(clk), .rst(rst), .tick(tick), .mode_in(mode_sel), .bias_in(bias_half),
    .row(row_sel), .neg(neg), .act_mode(act_mode), .act_half(act_half)
  );

  lcd_bp_drive #(.NBP(NBP)) u_bp (
    .clk(clk), .rst(rst), .en(disp_en), .row(row_sel), .neg(neg),
    .act_mode(act_mode), .act_half(act_half), .bp_lvl(bp_lvl)
  );

  lcd_seg_drive #(.NSEG(NSEG)) u_seg (
    .clk(clk), .rst(rst), .en(disp_en), .neg(neg), .stat(act_mode == '0),
    .act_half(act_half), .seg_on(seg_bits), .seg_lvl(seg_lvl)
  );
endmodule

// File: rtl/lcd_wave_seq_chk.sv
module lcd_wave_seq_chk #(
  parameter int NBP  = 4,
  parameter int NSEG = 60,
  localparam int RW = $clog2(NBP),
  localparam int LW = 3
) (
  input logic               clk,
  input logic               rst,
  input logic               tick,
  input logic               disp_en,
  input logic [RW-1:0]      row_sel,
  input logic [RW-1:0]      act_mode,
  input logic [NBP*LW-1:0]  bp_lvl,
  input logic [NSEG*LW-1:0] seg_lvl
);
  logic all_legal;
  always_comb begin
    all_legal = 1'b1;
    for (int k = 0; k < NBP; k++)
      if (bp_lvl[k*LW +: LW] > 3'd4) all_legal = 1'b0;
    for (int j = 0; j < NSEG; j++)
      if (seg_lvl[j*LW +: LW] > 3'd4) all_legal = 1'b0;
  end

  AST_BLANK_BP: assert property (@(posedge clk) disable iff (rst) !disp_en |=> (bp_lvl == '0)); // R7
  AST_BLANK_SEG: assert property (@(posedge clk) disable iff (rst) !disp_en |=> (seg_lvl == '0)); // R7
  AST_ROW_HOLD: assert property (@(posedge clk) disable iff (rst) !tick |=> $stable(row_sel)); // R1
  AST_ROW_STEP: assert property (@(posedge clk) disable iff (rst) tick |=> ((row_sel == $past(row_sel) + 1'b1) || (row_sel == '0))); // R1
  AST_ROW_BOUND: assert property (@(posedge clk) disable iff (rst) row_sel <= act_mode); // R1
  AST_UNUSED_BP: assert property (@(posedge clk) disable iff (rst) (act_mode != RW'(NBP-1)) |=> (bp_lvl[NBP*LW-1 -: LW] == '0)); // R6
  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst) !tick |=> $stable(act_mode)); // R8
  AST_LEVEL_RANGE: assert property (@(posedge clk) disable iff (rst) all_legal); // R2
endmodule

bind lcd_wave_seq lcd_wave_seq_chk #(.NBP(NBP), .NSEG(NSEG)) u_chk (
  .clk(clk), .rst(rst), .tick(tick), .disp_en(disp_en), .row_sel(row_sel),
  .act_mode(act_mode), .bp_lvl(bp_lvl), .seg_lvl(seg_lvl)
);

// File: tb/sim_lcd_wave_seq.sv
`timescale 1ns/1ps
module sim_lcd_wave_seq;
  localparam int NBP = 4, NSEG = 60, LW = 3;

  logic clk = 1'b0, rst = 1'b1, tick = 1'b0, bias_half = 1'b0, disp_en = 1'b0;
  logic [1:0] mode_sel = 2'd0;
  logic [NSEG-1:0] seg_bits;
  logic [1:0] row_sel;
  logic [NBP*LW-1:0] bp_lvl;
  logic [NSEG*LW-1:0] seg_lvl;
  logic [NSEG-1:0] ram [NBP];

  int n_cmp = 0, n_bad = 0, cyc = 0;
  int m_row = 0, m_mode = 3;
  bit m_neg = 0, m_half = 0;

  always #5 clk = ~clk;
  assign seg_bits = ram[row_sel];

  lcd_wave_seq #(.NBP(NBP), .NSEG(NSEG)) u0 (
    .clk(clk), .rst(rst), .tick(tick), .mode_sel(mode_sel), .bias_half(bias_half),
    .disp_en(disp_en), .seg_bits(seg_bits), .row_sel(row_sel), .bp_lvl(bp_lvl), .seg_lvl(seg_lvl)
  );

  function automatic logic [2:0] mir(int c, bit n);
    return n ? 3'(4 - c) : 3'(c);
  endfunction

  function automatic logic [NBP*LW-1:0] exp_bp();
    logic [NBP*LW-1:0] v = '0;
    for (int k = 0; k < NBP; k++) begin
      int b;
      if (!disp_en || k > m_mode) continue;
      b = (k == m_row || m_mode == 0) ? 4 : (m_half ? 2 : 1);
      v[k*LW +: LW] = mir(b, m_neg);
    end
    return v;
  endfunction

  function automatic logic [NSEG*LW-1:0] exp_seg();
    logic [NSEG*LW-1:0] v = '0;
    for (int j = 0; j < NSEG; j++) begin
      int b;
      if (!disp_en) continue;
      b = ram[m_row][j] ? 0 : (m_mode == 0 ? 4 : (m_half ? 2 : 3));
      v[j*LW +: LW] = mir(b, m_neg);
    end
    return v;
  endfunction

  function automatic string tag();
    if (!disp_en) return "R7";
    if (m_mode == 0) return "R3";
    return m_half ? "R5" : "R4";
  endfunction

  task automatic cmp(string req, logic [255:0] act, logic [255:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_all();
    logic [NBP*LW-1:0] eb = exp_bp();
    cmp("R1", 256'(row_sel), 256'(m_row));
    cmp(tag(), 256'(seg_lvl), 256'(exp_seg()));
    for (int k = 0; k < NBP; k++)
      cmp((disp_en && k > m_mode) ? "R6" : tag(), 256'(bp_lvl[k*LW +: LW]), 256'(eb[k*LW +: LW]));
  endtask

  task automatic model_step();
    if (m_row == m_mode) begin
      m_row = 0;
      if (m_neg) begin m_mode = int'(mode_sel); m_half = bias_half; end
      m_neg = ~m_neg;
    end else m_row++;
  endtask

  task automatic do_tick();
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
    model_step();
    @(negedge clk);
    check_all();
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk) cyc++;
      if (cyc > 150000) begin
        n_bad++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
        finish_run();
      end
    end
  end

  initial begin
    logic [NBP*LW-1:0] held;
    void'($urandom(32'd20240611));
    for (int r = 0; r < NBP; r++) ram[r] = {$urandom, $urandom};
    repeat (3) @(negedge clk);
    // R10: reset state
    cmp("R10", 256'(row_sel), 256'd0);
    cmp("R10", 256'(bp_lvl), 256'd0);
    cmp("R10", 256'(seg_lvl), 256'd0);
    rst = 1'b0;
    disp_en = 1'b1;
    mode_sel = 2'd0;  // requested static, but R8: default four rows stay until frame end
    @(negedge clk);
    check_all();
    for (int i = 0; i < 8; i++) do_tick();  // full first frame under default config (R8)
    // now static is active; directed static checks (R3) with edge patterns
    ram[0] = '1; do_tick();
    ram[0] = '0; do_tick();
    // R9: row moves on tick edge, levels one edge later
    mode_sel = 2'd3; bias_half = 1'b1;
    do_tick(); do_tick();  // static frame wraps, 1:4 half bias now active
    held = bp_lvl;
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
    model_step();
    cmp("R9", 256'(row_sel), 256'(m_row));
    cmp("R9", 256'(bp_lvl), 256'(held));
    @(negedge clk);
    check_all();
    // mid-frame request must not act before the frame ends (R8)
    mode_sel = 2'd1; bias_half = 1'b0;
    do_tick(); do_tick();
    cmp("R8", 256'(row_sel), 256'd3);
    // R7: blank after one edge, no tick
    @(negedge clk) disp_en = 1'b0;
    @(negedge clk);
    cmp("R7", 256'(bp_lvl), 256'd0);
    cmp("R7", 256'(seg_lvl), 256'd0);
    disp_en = 1'b1;
    // random mix
    for (int it = 0; it < 600; it++) begin
      if ($urandom_range(0, 9) == 0) mode_sel = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 9) == 0) bias_half = 1'($urandom_range(0, 1));
      disp_en = ($urandom_range(0, 7) != 0);
      if ($urandom_range(0, 3) == 0) ram[$urandom_range(0, 3)] = {$urandom, $urandom};
      do_tick();
    end
    finish_run();
  end
endmodule